// File: doc/BRIEF.md
# IEC 60958 Audio Subframe Formatter

This block takes one multichannel PCM audio frame at a time and sends its samples out one channel per word on a 32-bit AXI4-Stream master port. Each word is a complete IEC 60958-style subframe. It holds the 24-bit sample, the validity, user and channel-status flags, an even-parity bit, and a 4-bit code that gives the subframe kind and marks the start of a block. The channel index of each word travels on the stream ID.

A frame enters through a valid/ready handshake. The frame carries every channel's sample and that channel's validity and user flags. The block captures the frame and leaves its frame input not-ready while it sends the words in ascending channel order. It returns to ready once the downstream side has taken the last word. A counter tracks the frame position inside a 192-frame channel-status block. The counter picks the channel-status bit from a 192-bit input vector and decides where the block-start code is used. The stream clock must be at least 128 times the sample rate, so that every frame drains before the next one arrives.

The control is a two-state machine. ST_IDLE is ready for a frame. ST_SEND presents words. The transitions are: ST_IDLE to ST_SEND on frame accept; ST_SEND to ST_SEND on an accepted word that is not the last; ST_SEND to ST_IDLE on the accepted last word.

Top module: `iec_subframe_formatter`

## Requirements
- R1: While reset (active low, synchronous) is applied and in the first cycle after it, `frm_ready` is 1 and `m_tvalid` is 0, and the first frame sent after reset is at block position 0.
- R2: Each word has this layout: bit 31 parity, bit 30 channel status, bit 29 user flag, bit 28 validity flag, bits 27:4 the channel's 24-bit sample, bits 3:0 the preamble code.
- R3: Odd-indexed channels use preamble code 4'b0011. Even-indexed channels use 4'b0010 when the block position is not 0.
- R4: A frame produces exactly NUM_CH words. Their `m_tid` values run 0, 1, ... NUM_CH-1 in that order.
- R5: Bits 31:4 of every word hold an even number of ones.
- R6: The block position advances by one after each frame's last word and wraps from 191 to 0. Even-indexed channels of a frame at position 0 use preamble code 4'b0001.
- R7: The channel-status bit of every word in a frame equals `cs_block[p]`, where p is that frame's block position.
- R8: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tid` keep their values in the next cycle.
- R9: `frm_ready` is 0 while a frame's words are pending. Frame inputs that change during that time have no effect on the words sent.
- R10: In the cycle after the last word is accepted, `frm_ready` is 1 and `m_tvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_valid | input | 1 | Frame offered |
| frm_ready | output | 1 | Frame can be accepted |
| frm_samples | input | NUM_CH*24 | Samples, channel c at bits [c*24 +: 24] |
| frm_vflags | input | NUM_CH | Validity flag per channel |
| frm_uflags | input | NUM_CH | User flag per channel |
| cs_block | input | 192 | Channel-status bits indexed by block position |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream word accepted |
| m_tdata | output | 32 | Subframe word |
| m_tid | output | 3 | Channel index of the word |

## Verification
The first frame after reset is sent with the output always ready. This shows the block-start code and the parity and layout on a clean stream. A second frame is sent with the output held not-ready on every third word, which separates correct hold behaviour from a design that advances or rewrites the word during a stall. A third frame changes its inputs and keeps offering a new frame while it is being sent, so a design that captures the frame late or accepts early is caught. A long run of frames then crosses the 191-to-0 wrap. This tells a correct block counter from one that is off by one or wraps at the wrong length, through both the preamble codes and the channel-status bits at positions 191 and 0.

// File: rtl/iec_fmt_pkg.sv
package iec_fmt_pkg;

    localparam int SAMPLE_W  = 24;
    localparam int MAX_CH    = 8;
    localparam int TID_W     = 3;
    localparam int WORD_W    = 32;

    typedef enum logic [3:0] {
        PRE_BLOCK  = 4'b0001,
        PRE_FIRST  = 4'b0010,
        PRE_SECOND = 4'b0011
    } preamble_e;

    typedef enum logic {
        ST_IDLE,
        ST_SEND
    } fsm_e;

    typedef struct packed {
        logic                parity;
        logic                chstat;
        logic                user;
        logic                valid;
        logic [SAMPLE_W-1:0] sample;
        preamble_e           pre;
    } subframe_t;

endpackage

// File: rtl/iec_block_counter.sv
module iec_block_counter #(
    parameter int BLOCK_LEN = 192,
    localparam int CW = $clog2(BLOCK_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [CW-1:0] position,
    output logic          at_start
);

    localparam logic [CW-1:0] LAST_POS = CW'(BLOCK_LEN - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            position <= '0;
        end else if (advance) begin
            position <= (position == LAST_POS) ? '0 : position + 1'b1;
        end
    end

    assign at_start = (position == '0);

endmodule

// File: rtl/iec_word_pack.sv
module iec_word_pack
    import iec_fmt_pkg::*;
(
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                vflag,
    input  logic                uflag,
    input  logic                cflag,
    input  logic                second_sub,
    input  logic                block_start,
    output logic [WORD_W-1:0]   word
);

    subframe_t sf;

    always_comb begin
        sf.sample = sample;
        sf.valid  = vflag;
        sf.user   = uflag;
        sf.chstat = cflag;
        if (second_sub) begin
            sf.pre = PRE_SECOND;
        end else if (block_start) begin
            sf.pre = PRE_BLOCK;
        end else begin
            sf.pre = PRE_FIRST;
        end
        sf.parity = ^{cflag, uflag, vflag, sample};
        word      = sf;
    end

endmodule

// File: rtl/iec_subframe_formatter.sv
module iec_subframe_formatter
    import iec_fmt_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int BLOCK_LEN = 192
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frm_valid,
    output logic                       frm_ready,
    input  logic [NUM_CH*SAMPLE_W-1:0] frm_samples,
    input  logic [NUM_CH-1:0]          frm_vflags,
    input  logic [NUM_CH-1:0]          frm_uflags,
    input  logic [BLOCK_LEN-1:0]       cs_block,
    output logic                       m_tvalid,
    input  logic                       m_tready,
    output logic [WORD_W-1:0]          m_tdata,
    output logic [TID_W-1:0]           m_tid
);

    localparam int               PAD_W   = MAX_CH * SAMPLE_W;
    localparam int               CW      = $clog2(BLOCK_LEN);
    localparam logic [TID_W-1:0] LAST_CH = TID_W'(NUM_CH - 1);

    fsm_e              state_q, state_d;
    logic [TID_W-1:0]  ch_q;
    logic [PAD_W-1:0]  smp_q;
    logic [MAX_CH-1:0] v_q, u_q;
    logic [CW-1:0]     blk_pos;
    logic              blk_start;
    logic              frame_take, beat, last_beat;

    assign frame_take = frm_valid && frm_ready;
    assign beat       = m_tvalid && m_tready;
    assign last_beat  = beat && (ch_q == LAST_CH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (frame_take) state_d = ST_SEND;
            ST_SEND: if (last_beat)  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        frm_ready = 1'b0;
        m_tvalid  = 1'b0;
        unique case (state_q)
            ST_IDLE: frm_ready = 1'b1;
            ST_SEND: m_tvalid  = 1'b1;
        endcase
    end

    // frame capture and channel index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q  <= '0;
            smp_q <= '0;
            v_q   <= '0;
            u_q   <= '0;
        end else if (frame_take) begin
            ch_q  <= '0;
            smp_q <= PAD_W'(frm_samples);
            v_q   <= MAX_CH'(frm_vflags);
            u_q   <= MAX_CH'(frm_uflags);
        end else if (beat && !last_beat) begin
            ch_q  <= ch_q + 1'b1;
        end
    end

    iec_block_counter #(
        .BLOCK_LEN(BLOCK_LEN)
    ) u_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (last_beat),
        .position(blk_pos),
        .at_start(blk_start)
    );

    iec_word_pack u_pack (
        .sample     (smp_q[int'(ch_q)*SAMPLE_W +: SAMPLE_W]),
        .vflag      (v_q[ch_q]),
        .uflag      (u_q[ch_q]),
        .cflag      (cs_block[blk_pos]),
        .second_sub (ch_q[0]),
        .block_start(blk_start),
        .word       (m_tdata)
    );

    assign m_tid = ch_q;

endmodule

// File: rtl/iec_formatter_checks.sv
module iec_formatter_checks #(
    parameter int NUM_CH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        frm_ready,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic [31:0] m_tdata,
    input logic [2:0]  m_tid
);

    localparam logic [2:0] LAST_CH = 3'(NUM_CH - 1);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tid))); // R8

    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> ($countones(m_tdata[31:4]) % 2 == 0)); // R5

    AST_SECOND_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tid[0]) |-> (m_tdata[3:0] == 4'b0011)); // R3

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> !frm_ready); // R9

    AST_TID_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tid != LAST_CH) |=> (m_tvalid && m_tid == $past(m_tid) + 3'd1)); // R4

    AST_FIRST_TID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_tvalid) |-> (m_tid == 3'd0)); // R4

    AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tid == LAST_CH) |=> (frm_ready && !m_tvalid)); // R10

endmodule

bind iec_subframe_formatter iec_formatter_checks #(
    .NUM_CH(NUM_CH)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_ready(frm_ready),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tid    (m_tid)
);

// File: tb/iec_subframe_formatter_test.sv
module iec_subframe_formatter_test;

    localparam int NCH = 8;
    localparam int BL  = 192;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              frm_valid;
    logic              frm_ready;
    logic [NCH*24-1:0] frm_samples;
    logic [NCH-1:0]    frm_vflags, frm_uflags;
    logic [BL-1:0]     cs_block;
    logic              m_tvalid, m_tready;
    logic [31:0]       m_tdata;
    logic [2:0]        m_tid;

    int n_checks = 0;
    int n_fail   = 0;
    int fc       = 0;
    int frame_no = 0;

    always #4 clk = ~clk;

    iec_subframe_formatter #(.NUM_CH(NCH), .BLOCK_LEN(BL)) uut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_samples(frm_samples), .frm_vflags(frm_vflags), .frm_uflags(frm_uflags),
        .cs_block(cs_block), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tdata(m_tdata), .m_tid(m_tid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [23:0] s, input logic v, input logic u,
                                             input int ch, input int pos);
        logic [31:0] w;
        logic [3:0]  pre;
        pre = (ch % 2 == 1) ? 4'b0011 : ((pos == 0) ? 4'b0001 : 4'b0010);
        w = {1'b0, cs_block[pos], u, v, s, pre};
        w[31] = ^w[30:4];
        return w;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; frm_valid = 1'b0; m_tready = 1'b0;
        frm_samples = '0; frm_vflags = '0; frm_uflags = '0;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", 32'(frm_ready), 32'd1);
        chk("R1 tvalid in reset", 32'(m_tvalid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(frm_ready), 32'd1);
        chk("R1 tvalid after reset", 32'(m_tvalid), 32'd0);
    endtask

    // Sends one frame; stall inserts a one-cycle hold on every third word,
    // poke keeps offering altered frames while the words drain.
    task automatic send_frame(input bit stall, input bit poke);
        logic [23:0] s [NCH];
        logic [NCH-1:0] v, u;
        logic [31:0] held;
        logic [31:0] ew;
        for (int c = 0; c < NCH; c++) begin
            s[c] = 24'(frame_no * 37 + c * 4099 + 24'h5A5A0);
            v[c] = ((frame_no + c) % 3 == 0);
            u[c] = ((frame_no ^ c) & 1) == 1;
            frm_samples[c*24 +: 24] = s[c];
        end
        frm_vflags = v; frm_uflags = u; frm_valid = 1'b1;
        while (!frm_ready) @(negedge clk);
        @(negedge clk);
        frm_valid = poke;
        if (poke) begin
            frm_samples = ~frm_samples; frm_vflags = ~v; frm_uflags = ~u;
        end
        for (int c = 0; c < NCH; c++) begin
            ew = exp_word(s[c], v[c], u[c], c, fc);
            if (stall && (c % 3 == 0)) begin
                m_tready = 1'b0;
                held = m_tdata;
                @(negedge clk);
                chk("R8 hold valid", 32'(m_tvalid), 32'd1);
                chk("R8 hold data", m_tdata, held);
                chk("R8 hold tid", 32'(m_tid), 32'(c));
            end
            m_tready = 1'b1;
            chk("R4 valid", 32'(m_tvalid), 32'd1);
            chk("R4 tid", 32'(m_tid), 32'(c));
            chk(poke ? "R9 word unchanged by busy input" : "R2 word", m_tdata, ew);
            chk((fc == 0 && c % 2 == 0) ? "R6 block start code" : "R3 preamble",
                32'(m_tdata[3:0]), 32'(ew[3:0]));
            chk("R5 parity", 32'(^m_tdata[31:4]), 32'd0);
            chk((fc == BL - 1) ? "R7 cs bit at last position" : "R7 cs bit",
                32'(m_tdata[30]), 32'(cs_block[fc]));
            chk("R9 busy not ready", 32'(frm_ready), 32'd0);
            @(negedge clk);
        end
        m_tready = 1'b0;
        frm_valid = 1'b0;
        chk("R10 ready after last", 32'(frm_ready), 32'd1);
        chk("R10 idle after last", 32'(m_tvalid), 32'd0);
        fc = (fc + 1) % BL;
        frame_no++;
    endtask

    task automatic test_plain();
        send_frame(1'b0, 1'b0);
    endtask

    task automatic test_stall();
        send_frame(1'b1, 1'b0);
    endtask

    task automatic test_busy();
        send_frame(1'b0, 1'b1);
    endtask

    task automatic test_wrap();
        while (frame_no < BL + 1) send_frame(frame_no % 17 == 5, 1'b0);
        chk("R6 position wrapped to 0", 32'(fc), 32'd1);
    endtask

    initial begin
        for (int i = 0; i < BL; i++) cs_block[i] = ((i * 7) % 5 < 2);
        cs_block[0]      = 1'b1;
        cs_block[1]      = 1'b0;
        cs_block[BL - 1] = 1'b1;
        @(negedge clk);
        do_reset();
        test_plain();
        test_stall();
        test_busy();
        test_wrap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule